// File: doc/BRIEF.md
# Staged Reset Sequencer for a Line Transceiver

This block decides when a transceiver-style device is held in reset and when it comes back out. Three things can start a reset. The first is the supply-good indication rising at power-up. The second is an active-low reset pin, which counts only once it has stayed low long enough. The third is a one-shot write to a self-clearing software reset bit in the management control register. The analog supply detector, the PLL and the clock recovery are not part of the block. It sees them only as the inputs `pwr_good`, `tx_clk_ok` and `rx_clk_ok`.

Coming out of reset happens in two stages. After a fixed run of exit steps, the management port is usable again, and at that moment a one-cycle pulse tells the register file to load its default values. The data path stays closed until both line clocks report valid, which may take a long time. The MAC-side interface enable also drops at once if either clock is lost.

The sequencer is a single state machine with these states: POWER_WAIT, POR_HOLD, RESET_HOLD, EXIT_STEPS, MGMT_READY and RUN. Its transitions are:
- supply good: POWER_WAIT to POR_HOLD
- dwell done: POR_HOLD to EXIT_STEPS
- pin released: RESET_HOLD to EXIT_STEPS
- exit done: EXIT_STEPS to MGMT_READY
- clocks valid: MGMT_READY to RUN
- clock lost: RUN to MGMT_READY
- pin reset: EXIT_STEPS, MGMT_READY or RUN to RESET_HOLD
- software reset: MGMT_READY or RUN to EXIT_STEPS

A low `pwr_good` forces POWER_WAIT from any state.

Top module: `phy_rst_seq`

## Requirements
- R1: While `pwr_good` is low, the sequencer stays in POWER_WAIT with `state_code` = 0. In that state `in_reset` is 1, and `mgmt_ready`, `data_ready`, `mac_if_en`, `load_defaults` and `sw_rst_bit` are all 0.
- R2: Count rising edges from the first edge that sees `pwr_good` high. POR_HOLD lasts POR_CYCLES clocks and is followed by EXIT_STEPS. `mgmt_ready` is first high after edge number POR_CYCLES + EXIT_CYCLES + 1 in that count.
- R3: During POR_HOLD the reset pin has no effect. A low pin in that state never leads to RESET_HOLD, and its low-width count starts again from zero afterwards.
- R4: The pin goes through a two-flop synchronizer. A low that is sampled on MIN_LOW_CYCLES (5) or more consecutive edges sends the sequencer to RESET_HOLD (`state_code` 2, `in_reset` 1). A low sampled on 4 or fewer edges has no effect.
- R5: Count from the first edge that samples the pin high in RESET_HOLD. The state is EXIT_STEPS after edge 3, and `mgmt_ready` is first high after edge 3 + EXIT_CYCLES. With the default of 16 exit steps, that is edge 19.
- R6: `load_defaults` is high for exactly one cycle, in the first cycle of MGMT_READY that follows every EXIT_STEPS, whatever started the reset.
- R7: RUN (`state_code` 5, `data_ready` 1) is entered only from MGMT_READY, on the edge after both `tx_clk_ok` and `rx_clk_ok` are high. From RUN, the state returns to MGMT_READY (`state_code` 4) on the edge after either of them is low.
- R8: `mac_if_en` equals `data_ready` AND `tx_clk_ok` AND `rx_clk_ok`, with no clock delay. It is 0 outside RUN.
- R9: A `sw_rst_wr` pulse sampled in MGMT_READY or RUN moves the state to EXIT_STEPS (`state_code` 3) on that edge and sets `sw_rst_bit` to 1. The bit reads 0 again in the cycle of the `load_defaults` pulse, which comes EXIT_CYCLES edges later.
- R10: `sw_rst_bit` is never set by a power-on or pin reset. A `sw_rst_wr` sampled in POWER_WAIT, POR_HOLD, RESET_HOLD or EXIT_STEPS is ignored.
- R11: A qualified pin reset in EXIT_STEPS, MGMT_READY or RUN moves the state to RESET_HOLD and clears `sw_rst_bit`. This takes priority over a software write.
- R12: `state_code` encodes the states as POWER_WAIT 0, POR_HOLD 1, RESET_HOLD 2, EXIT_STEPS 3, MGMT_READY 4 and RUN 5. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_good | input | 1 | Supply-good flag. Low forces POWER_WAIT |
| rst_pin_n | input | 1 | Active-low external reset pin, asynchronous |
| sw_rst_wr | input | 1 | One-cycle write of 1 to the software reset bit |
| tx_clk_ok | input | 1 | Transmit clock reported valid |
| rx_clk_ok | input | 1 | Receive clock reported valid |
| in_reset | output | 1 | Device held in reset or running exit steps |
| mgmt_ready | output | 1 | Management port usable |
| data_ready | output | 1 | Data path usable (state RUN) |
| mac_if_en | output | 1 | MAC-side interface enable |
| load_defaults | output | 1 | One-cycle pulse telling the register file to load defaults |
| sw_rst_bit | output | 1 | Read-back value of the self-clearing software reset bit |
| state_code | output | 3 | Current state encoding |

## Verification
Some rules are checked by assertions on every cycle:
- the data path is never ready without the management port and both clocks;
- the interface enable is always gated by both clocks;
- the defaults pulse lasts one cycle and comes with every rise of management readiness;
- the software bit rises only from a write in a ready state and is clear at the defaults pulse;
- POR_HOLD never hands over to RESET_HOLD.

Other behaviour can be shown only by the bench's scenarios:
- the exact edge counts of the power-on dwell and the exit steps;
- the 4-cycle versus 5-cycle threshold for pin pulses;
- pin isolation during the power-on dwell;
- the priority of a pin reset over a software reset already in progress.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_POWER_WAIT = 3'd0,
        ST_POR_HOLD   = 3'd1,
        ST_RESET_HOLD = 3'd2,
        ST_EXIT_STEPS = 3'd3,
        ST_MGMT_READY = 3'd4,
        ST_RUN        = 3'd5
    } rst_state_e;

endpackage

// File: rtl/rst_pin_qual.sv
// Synchronizes the asynchronous reset pin and counts consecutive low samples.
module rst_pin_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 5
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic pin_n,
    input  logic isolate,
    output logic pin_high,
    output logic qualified
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       low_cnt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!pwr_good) sync_q <= '1;
                else           sync_q <= pin_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!pwr_good) sync_q <= '1;
                else           sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign pin_high = sync_q[SYNC_STAGES-1];

    // Saturating count of consecutive synchronized low samples.
    always_ff @(posedge clk) begin
        if (!pwr_good || isolate || pin_high) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_MAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign qualified = (low_cnt == CNT_MAX);

endmodule

// File: rtl/rst_dwell_cnt.sv
// Counts clocks while run is high; done flags the last cycle of a LIMIT-cycle stay.
module rst_dwell_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!pwr_good || !run) cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import phy_rst_pkg::*;
(
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       pin_high,
    input  logic       pin_qual,
    input  logic       por_done,
    input  logic       exit_done,
    input  logic       sw_rst_wr,
    input  logic       clks_ok,
    output rst_state_e state,
    output logic       in_reset,
    output logic       mgmt_ready,
    output logic       data_ready,
    output logic       load_defaults,
    output logic       sw_rst_bit
);
    rst_state_e state_q, state_d;
    logic       sw_take;

    // State register
    always_ff @(posedge clk) begin
        if (!pwr_good) state_q <= ST_POWER_WAIT;
        else           state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        sw_take = 1'b0;
        unique case (state_q)
            ST_POWER_WAIT: state_d = ST_POR_HOLD;
            ST_POR_HOLD:   if (por_done) state_d = ST_EXIT_STEPS;
            ST_RESET_HOLD: if (pin_high) state_d = ST_EXIT_STEPS;
            ST_EXIT_STEPS: begin
                if (pin_qual)       state_d = ST_RESET_HOLD;
                else if (exit_done) state_d = ST_MGMT_READY;
            end
            ST_MGMT_READY: begin
                if (pin_qual) begin
                    state_d = ST_RESET_HOLD;
                end else if (sw_rst_wr) begin
                    state_d = ST_EXIT_STEPS;
                    sw_take = 1'b1;
                end else if (clks_ok) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (pin_qual) begin
                    state_d = ST_RESET_HOLD;
                end else if (sw_rst_wr) begin
                    state_d = ST_EXIT_STEPS;
                    sw_take = 1'b1;
                end else if (!clks_ok) begin
                    state_d = ST_MGMT_READY;
                end
            end
            default: state_d = ST_POWER_WAIT;
        endcase
    end

    // Registered outputs, computed from the next state
    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            in_reset      <= 1'b1;
            mgmt_ready    <= 1'b0;
            data_ready    <= 1'b0;
            load_defaults <= 1'b0;
            sw_rst_bit    <= 1'b0;
        end else begin
            in_reset      <= (state_d == ST_POWER_WAIT) || (state_d == ST_POR_HOLD) ||
                             (state_d == ST_RESET_HOLD) || (state_d == ST_EXIT_STEPS);
            mgmt_ready    <= (state_d == ST_MGMT_READY) || (state_d == ST_RUN);
            data_ready    <= (state_d == ST_RUN);
            load_defaults <= (state_q == ST_EXIT_STEPS) && (state_d == ST_MGMT_READY);
            if (sw_take) begin
                sw_rst_bit <= 1'b1;
            end else if (state_d == ST_RESET_HOLD ||
                         (state_q == ST_EXIT_STEPS && state_d == ST_MGMT_READY)) begin
                sw_rst_bit <= 1'b0;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
    import phy_rst_pkg::*;
#(
    parameter int POR_CYCLES     = 500,
    parameter int EXIT_CYCLES    = 16,
    parameter int MIN_LOW_CYCLES = 5,
    parameter int SYNC_STAGES    = 2
) (
    input  logic               clk,
    input  logic               pwr_good,
    input  logic               rst_pin_n,
    input  logic               sw_rst_wr,
    input  logic               tx_clk_ok,
    input  logic               rx_clk_ok,
    output logic               in_reset,
    output logic               mgmt_ready,
    output logic               data_ready,
    output logic               mac_if_en,
    output logic               load_defaults,
    output logic               sw_rst_bit,
    output logic [STATE_W-1:0] state_code
);
    rst_state_e state;
    logic       pin_high, pin_qual, por_done, exit_done, clks_ok;

    assign clks_ok = tx_clk_ok && rx_clk_ok;

    rst_pin_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_LOW     (MIN_LOW_CYCLES)
    ) u_pin (
        .clk       (clk),
        .pwr_good  (pwr_good),
        .pin_n     (rst_pin_n),
        .isolate   (state == ST_POR_HOLD || state == ST_POWER_WAIT),
        .pin_high  (pin_high),
        .qualified (pin_qual)
    );

    rst_dwell_cnt #(.LIMIT(POR_CYCLES)) u_por_cnt (
        .clk      (clk),
        .pwr_good (pwr_good),
        .run      (state == ST_POR_HOLD),
        .done     (por_done)
    );

    rst_dwell_cnt #(.LIMIT(EXIT_CYCLES)) u_exit_cnt (
        .clk      (clk),
        .pwr_good (pwr_good),
        .run      (state == ST_EXIT_STEPS),
        .done     (exit_done)
    );

    rst_seq_fsm u_fsm (
        .clk           (clk),
        .pwr_good      (pwr_good),
        .pin_high      (pin_high),
        .pin_qual      (pin_qual),
        .por_done      (por_done),
        .exit_done     (exit_done),
        .sw_rst_wr     (sw_rst_wr),
        .clks_ok       (clks_ok),
        .state         (state),
        .in_reset      (in_reset),
        .mgmt_ready    (mgmt_ready),
        .data_ready    (data_ready),
        .load_defaults (load_defaults),
        .sw_rst_bit    (sw_rst_bit)
    );

    assign mac_if_en  = data_ready && clks_ok;
    assign state_code = state;

endmodule

// File: rtl/phy_rst_seq_chk.sv
module phy_rst_seq_chk (
    input logic       clk,
    input logic       pwr_good,
    input logic       sw_rst_wr,
    input logic       tx_clk_ok,
    input logic       rx_clk_ok,
    input logic       in_reset,
    input logic       mgmt_ready,
    input logic       data_ready,
    input logic       mac_if_en,
    input logic       load_defaults,
    input logic       sw_rst_bit,
    input logic [2:0] state_code
);
    // R2
    por_entry_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (state_code == 3'd0) |=> (state_code == 3'd1));

    // R3
    por_pin_isolate_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (state_code == 3'd1) |=> (state_code != 3'd2));

    // R6
    load_pulse_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        load_defaults |=> !load_defaults);

    // R6
    load_on_ready_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(mgmt_ready) |-> load_defaults);

    // R7
    run_needs_clks_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(data_ready) |-> $past(tx_clk_ok && rx_clk_ok));

    // R7
    ready_order_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        data_ready |-> (mgmt_ready && !in_reset));

    // R8
    mac_gate_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        mac_if_en |-> (data_ready && tx_clk_ok && rx_clk_ok));

    // R9
    sw_clear_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        load_defaults |-> !sw_rst_bit);

    // R10
    sw_origin_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(sw_rst_bit) |-> $past(mgmt_ready && sw_rst_wr));

    // R12
    state_legal_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        state_code <= 3'd5);

endmodule

bind phy_rst_seq phy_rst_seq_chk u_chk (
    .clk           (clk),
    .pwr_good      (pwr_good),
    .sw_rst_wr     (sw_rst_wr),
    .tx_clk_ok     (tx_clk_ok),
    .rx_clk_ok     (rx_clk_ok),
    .in_reset      (in_reset),
    .mgmt_ready    (mgmt_ready),
    .data_ready    (data_ready),
    .mac_if_en     (mac_if_en),
    .load_defaults (load_defaults),
    .sw_rst_bit    (sw_rst_bit),
    .state_code    (state_code)
);

// File: tb/phy_rst_seq_tb.sv
module phy_rst_seq_tb;
    localparam int POR_C  = 40;
    localparam int EXIT_C = 16;
    localparam int MINLOW = 5;
    localparam int SYNC   = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic pwr_good = 1'b0, rst_pin_n = 1'b1, sw_rst_wr = 1'b0;
    logic tx_clk_ok = 1'b0, rx_clk_ok = 1'b0;
    logic in_reset, mgmt_ready, data_ready, mac_if_en, load_defaults, sw_rst_bit;
    logic [2:0] state_code;

    int n_vec = 0;
    int n_bad = 0;

    phy_rst_seq #(
        .POR_CYCLES(POR_C), .EXIT_CYCLES(EXIT_C),
        .MIN_LOW_CYCLES(MINLOW), .SYNC_STAGES(SYNC)
    ) u_dut (
        .clk(clk), .pwr_good(pwr_good), .rst_pin_n(rst_pin_n), .sw_rst_wr(sw_rst_wr),
        .tx_clk_ok(tx_clk_ok), .rx_clk_ok(rx_clk_ok), .in_reset(in_reset),
        .mgmt_ready(mgmt_ready), .data_ready(data_ready), .mac_if_en(mac_if_en),
        .load_defaults(load_defaults), .sw_rst_bit(sw_rst_bit), .state_code(state_code)
    );

    function automatic int exp_reset(int w);
        return (w >= MINLOW) ? 1 : 0;
    endfunction

    function automatic int exp_pin_exit_edges();
        return SYNC + 1 + EXIT_C;
    endfunction

    function automatic int exp_por_edges();
        return POR_C + EXIT_C + 1;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Counts edges until mgmt_ready is seen high, capturing load and sw bit there.
    task automatic edges_to_ready(output int n, output int ld, output int sw);
        n = 0; ld = 0; sw = 1;
        for (int i = 1; i <= 400; i++) begin
            tick();
            if (mgmt_ready) begin
                n = i; ld = int'(load_defaults); sw = int'(sw_rst_bit);
                break;
            end
        end
    endtask

    task automatic get_to_run();
        tx_clk_ok = 1'b1; rx_clk_ok = 1'b1;
        for (int i = 0; i < 100; i++) begin
            if (state_code == 3'd5) break;
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n, ld, sw, saw, bad_state;
        void'($urandom(32'h5EED_0042));

        // R1 reset state
        repeat (3) tick();
        chk("R1 state", int'(state_code), 0);
        chk("R1 in_reset", int'(in_reset), 1);
        chk("R1 mgmt_ready", int'(mgmt_ready), 0);
        chk("R1 data_ready", int'(data_ready), 0);
        chk("R1 load", int'(load_defaults), 0);
        chk("R1 sw bit", int'(sw_rst_bit), 0);

        // R2 / R3: power-on with pin held low during the dwell
        pwr_good = 1'b1; rst_pin_n = 1'b0;
        n = 0; ld = 0; sw = 1; bad_state = 0;
        for (int i = 1; i <= 400; i++) begin
            tick();
            if (i == POR_C - 10) rst_pin_n = 1'b1;
            if (state_code == 3'd2) bad_state = 1;
            if (mgmt_ready) begin
                n = i; ld = int'(load_defaults); sw = int'(sw_rst_bit);
                break;
            end
        end
        chk("R2 por edges to mgmt_ready", n, exp_por_edges());
        chk("R3 pin ignored in POR_HOLD", bad_state, 0);
        chk("R6 load at por exit", ld, 1);
        chk("R10 sw bit after por", sw, 0);
        tick();
        chk("R6 load one cycle", int'(load_defaults), 0);

        // R7 wait for both clocks
        repeat (8) tick();
        chk("R7 waits clocks state", int'(state_code), 4);
        chk("R7 data_ready low", int'(data_ready), 0);
        chk("R8 mac_if_en low", int'(mac_if_en), 0);
        tx_clk_ok = 1'b1;
        repeat (3) tick();
        chk("R7 one clock only", int'(state_code), 4);
        rx_clk_ok = 1'b1;
        tick();
        chk("R7 run entered", int'(state_code), 5);
        chk("R7 data_ready", int'(data_ready), 1);
        chk("R8 mac_if_en", int'(mac_if_en), 1);

        // R8 immediate gating, R7 fall back
        tx_clk_ok = 1'b0;
        #1;
        chk("R8 mac drops at once", int'(mac_if_en), 0);
        tick();
        chk("R7 clock lost state", int'(state_code), 4);
        get_to_run();

        // R4 short pulse (4) and threshold pulse (5)
        for (int w = 4; w <= 5; w++) begin
            rst_pin_n = 1'b0;
            repeat (w) tick();
            rst_pin_n = 1'b1;
            saw = 0;
            repeat (40) begin
                tick();
                if (in_reset) saw = 1;
            end
            chk($sformatf("R4 pulse width %0d", w), saw, exp_reset(w));
            get_to_run();
        end

        // R4 / R11 long pin reset from RUN, R10 sw ignored in hold, R5 exit timing
        rst_pin_n = 1'b0;
        repeat (12) tick();
        chk("R4 hold state", int'(state_code), 2);
        chk("R4 in_reset", int'(in_reset), 1);
        chk("R11 mgmt_ready dropped", int'(mgmt_ready), 0);
        sw_rst_wr = 1'b1;
        tick();
        sw_rst_wr = 1'b0;
        chk("R10 sw ignored in hold state", int'(state_code), 2);
        chk("R10 sw bit stays 0", int'(sw_rst_bit), 0);
        rst_pin_n = 1'b1;
        edges_to_ready(n, ld, sw);
        chk("R5 pin exit edges", n, exp_pin_exit_edges());
        chk("R6 load at pin exit", ld, 1);
        chk("R10 sw bit after pin", sw, 0);
        get_to_run();

        // R9 software reset
        sw_rst_wr = 1'b1;
        tick();
        sw_rst_wr = 1'b0;
        chk("R9 sw state", int'(state_code), 3);
        chk("R9 sw bit set", int'(sw_rst_bit), 1);
        chk("R9 in_reset", int'(in_reset), 1);
        edges_to_ready(n, ld, sw);
        chk("R9 sw exit edges", n, EXIT_C);
        chk("R9 sw bit self-clears", sw, 0);
        chk("R6 load at sw exit", ld, 1);
        get_to_run();

        // R11 pin qualifies during a software exit
        rst_pin_n = 1'b0;
        repeat (3) tick();
        sw_rst_wr = 1'b1;
        tick();
        sw_rst_wr = 1'b0;
        chk("R11 sw started", int'(state_code), 3);
        repeat (6) tick();
        chk("R11 pin wins state", int'(state_code), 2);
        chk("R11 sw bit cleared", int'(sw_rst_bit), 0);
        rst_pin_n = 1'b1;
        get_to_run();

        // Random mix
        for (int it = 0; it < 60; it++) begin
            int act;
            act = int'($urandom_range(0, 2));
            if (act == 0) begin
                int w;
                w = int'($urandom_range(1, 8));
                rst_pin_n = 1'b0;
                repeat (w) tick();
                rst_pin_n = 1'b1;
                saw = 0;
                repeat (40) begin
                    tick();
                    if (in_reset) saw = 1;
                end
                chk($sformatf("R4 random width %0d", w), saw, exp_reset(w));
            end else if (act == 1) begin
                sw_rst_wr = 1'b1;
                tick();
                sw_rst_wr = 1'b0;
                chk("R9 random sw state", int'(state_code), 3);
                chk("R9 random sw bit", int'(sw_rst_bit), 1);
            end else begin
                int g;
                g = int'($urandom_range(1, 4));
                rx_clk_ok = 1'b0;
                #1;
                chk("R8 random mac gate", int'(mac_if_en), 0);
                repeat (g) tick();
                chk("R7 random clock loss", int'(state_code), 4);
                rx_clk_ok = 1'b1;
                tick();
                chk("R7 random recovery", int'(state_code), 5);
            end
            get_to_run();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule